// File: doc/BRIEF.md
# Packet Header ECC Unit

This unit protects the four-byte header of a serial display link packet with a one-byte error-correcting code. The header content is three bytes: a 6-bit data type and the virtual channel field in the low byte, then the low and high bytes of the word count (or two data bytes). The code is a Hamming-style code over a 64-bit word. The 24 header bits sit in the low positions and the upper 40 bits are zero pad. The pad contributes nothing to the parity, so six parity bits are computed in parallel from the 24 header bits alone.

The transmit path accepts a 24-bit header and returns the 32-bit header with the ECC byte appended. The receive path accepts a 32-bit header with its ECC byte. It recomputes the parity, forms a syndrome and returns the header, with a single-bit data error repaired, together with a two-bit status. Each path is a valid/ready stream with one register stage. A path accepts a new item when its output register is empty or is being drained in the same cycle, so back-pressure from the output reaches the input in the same cycle. An item held in the output register stays stable until the consumer takes it. Two plain enable inputs, one per direction, switch the coding on or off for every virtual channel. An enable is captured together with each accepted item.

Top module: `pkt_hdr_ecc`

## Requirements
- R1: With tx_en high, bits 5:0 of the appended ECC byte are P0..P5 over header bits D23..D0 (^ is XOR): P0=D0^D1^D2^D4^D5^D7^D10^D11^D13^D16^D20^D21^D22^D23, P1=D0^D1^D3^D4^D6^D8^D10^D12^D14^D17^D20^D21^D22^D23, P2=D0^D2^D3^D5^D6^D9^D11^D12^D15^D18^D20^D21^D22, P3=D1^D2^D3^D7^D8^D9^D13^D14^D15^D19^D20^D21^D23, P4=D4^D5^D6^D7^D8^D9^D16^D17^D18^D19^D20^D22^D23, P5=D10^D11^D12^D13^D14^D15^D16^D17^D18^D19^D21^D22^D23.
- R2: tx_out_pkt carries the ECC byte in bits 31:24 and the unchanged header in bits 23:0; ECC bits 7:6 (tx_out_pkt[31:30]) are always zero.
- R3: An item accepted with tx_en low leaves with ECC byte 0x00 and its header unchanged.
- R4: On receive, the syndrome is rx_in_pkt[29:24] XOR the parity recomputed per R1 over rx_in_pkt[23:0]; a zero syndrome gives status 2'b00 (clean) and the header unchanged.
- R5: A syndrome equal to the parity pattern of exactly one header bit flips that bit in rx_out_hdr and gives status 2'b01 (corrected).
- R6: A syndrome with exactly one bit set (a parity-bit error) gives status 2'b01 with the header unchanged.
- R7: Any other nonzero syndrome gives status 2'b10 (uncorrectable) with the header unchanged; status 2'b11 never appears.
- R8: An item accepted with rx_en low leaves with the header unchanged and status 2'b00 whatever its ECC byte holds.
- R9: Received bits 31:30 have no effect on rx_out_hdr or rx_out_status.
- R10: On each path, in_ready is high exactly when the output register is empty or out_ready is high. An accepted item appears at the output with out_valid high on the next cycle. While out_valid is high and out_ready is low, the output data and out_valid hold.
- R11: While rst_n is low and in the cycle after it, both out_valid outputs are low.
- R12: The enables act per item: the value of tx_en or rx_en in the cycle an item is accepted decides its coding, and later changes do not alter an item already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit ECC generation enable |
| rx_en | input | 1 | Receive ECC check/correct enable |
| tx_in_valid | input | 1 | Transmit header offered |
| tx_in_ready | output | 1 | Transmit header accepted this cycle when valid |
| tx_in_hdr | input | 24 | Header content to protect |
| tx_out_valid | output | 1 | Protected header available |
| tx_out_ready | input | 1 | Consumer takes protected header |
| tx_out_pkt | output | 32 | ECC byte (31:24) and header (23:0) |
| rx_in_valid | input | 1 | Received header offered |
| rx_in_ready | output | 1 | Received header accepted this cycle when valid |
| rx_in_pkt | input | 32 | Received ECC byte (31:24) and header (23:0) |
| rx_out_valid | output | 1 | Checked header available |
| rx_out_ready | input | 1 | Consumer takes checked header |
| rx_out_hdr | output | 24 | Header after correction |
| rx_out_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The assertions check the stream rules on every cycle: output hold under back-pressure, same-cycle ready from an empty stage, output valid one cycle after acceptance, and invalid outputs around reset. They also check structural facts of every item: zero upper ECC bits, no status 2'b11, and the exact pass-through of items taken with an enable low. Whether the parity bits are right and whether a given corruption is classified and repaired correctly is shown only by the bench. It compares directed corner headers and randomly corrupted headers (single data flips, parity flips, double flips, random bytes) against a model built from the parity equations.

// File: rtl/pkt_ecc_pkg.sv
package pkt_ecc_pkg;

  localparam int HDR_W = 24;
  localparam int PAR_W = 6;
  localparam int ECC_W = 8;
  localparam int PKT_W = HDR_W + ECC_W;
  localparam int STS_W = 2;

  typedef enum logic [STS_W-1:0] {
    ECC_CLEAN = 2'b00,
    ECC_FIXED = 2'b01,
    ECC_FATAL = 2'b10
  } ecc_status_e;

  // Parity pattern (P5..P0) contributed by one header bit.
  function automatic logic [PAR_W-1:0] data_col(input int idx);
    logic [PAR_W-1:0] c;
    case (idx)
      0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
      4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
      8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
      12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
      16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
      20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Header bits that feed parity bit `row`.
  function automatic logic [HDR_W-1:0] row_mask(input int row);
    logic [HDR_W-1:0] m;
    logic [PAR_W-1:0] c;
    m = '0;
    for (int i = 0; i < HDR_W; i++) begin
      c = data_col(i);
      m[i] = c[row];
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_parity_gen.sv
module ecc_parity_gen
  import pkt_ecc_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output logic [PAR_W-1:0] par
);
  // Pad bits above the header are zero and drop out of every XOR tree.
  for (genvar j = 0; j < PAR_W; j++) begin : g_row
    localparam logic [HDR_W-1:0] MASK = row_mask(j);
    assign par[j] = ^(hdr & MASK);
  end
endmodule

// File: rtl/ecc_rx_decode.sv
module ecc_rx_decode
  import pkt_ecc_pkg::*;
(
  input  logic             en,
  input  logic [PKT_W-1:0] pkt,
  output logic [HDR_W-1:0] hdr_out,
  output logic [STS_W-1:0] status
);
  logic [HDR_W-1:0] raw_hdr;
  logic [PAR_W-1:0] rx_par;
  logic [PAR_W-1:0] calc_par;
  logic [PAR_W-1:0] syn;
  logic [HDR_W-1:0] hit;
  logic             par_only;
  logic             unused_hi;

  assign raw_hdr   = pkt[HDR_W-1:0];
  assign rx_par    = pkt[HDR_W +: PAR_W];
  assign unused_hi = ^pkt[PKT_W-1:HDR_W+PAR_W];

  ecc_parity_gen u_regen (
    .hdr (raw_hdr),
    .par (calc_par)
  );

  assign syn = rx_par ^ calc_par;

  for (genvar i = 0; i < HDR_W; i++) begin : g_hit
    localparam logic [PAR_W-1:0] COL = data_col(i);
    assign hit[i] = (syn == COL);
  end

  assign par_only = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    hdr_out = raw_hdr;
    status  = ECC_CLEAN;
    if (en && (syn != '0)) begin
      if (|hit) begin
        hdr_out = raw_hdr ^ hit;
        status  = ECC_FIXED;
      end else if (par_only) begin
        status  = ECC_FIXED;
      end else begin
        status  = ECC_FATAL;
      end
    end
  end
endmodule

// File: rtl/ecc_pipe_stage.sv
module ecc_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/pkt_hdr_ecc.sv
module pkt_hdr_ecc
  import pkt_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [HDR_W-1:0] tx_in_hdr,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [PKT_W-1:0] tx_out_pkt,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [PKT_W-1:0] rx_in_pkt,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [HDR_W-1:0] rx_out_hdr,
  output logic [STS_W-1:0] rx_out_status
);
  localparam int RX_W = HDR_W + STS_W;

  // Transmit: code the header, gate by enable, register with the header.
  logic [PAR_W-1:0] tx_par;
  logic [ECC_W-1:0] tx_byte;

  ecc_parity_gen u_tx_gen (
    .hdr (tx_in_hdr),
    .par (tx_par)
  );

  assign tx_byte = tx_en ? {{(ECC_W-PAR_W){1'b0}}, tx_par} : '0;

  ecc_pipe_stage #(.W(PKT_W)) u_tx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   ({tx_byte, tx_in_hdr}),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_pkt)
  );

  // Receive: syndrome decode and repair, then register.
  logic [HDR_W-1:0] rx_fix_hdr;
  logic [STS_W-1:0] rx_fix_sts;
  logic [RX_W-1:0]  rx_q;

  ecc_rx_decode u_rx_dec (
    .en      (rx_en),
    .pkt     (rx_in_pkt),
    .hdr_out (rx_fix_hdr),
    .status  (rx_fix_sts)
  );

  ecc_pipe_stage #(.W(RX_W)) u_rx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   ({rx_fix_sts, rx_fix_hdr}),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_q)
  );

  assign rx_out_hdr    = rx_q[HDR_W-1:0];
  assign rx_out_status = rx_q[RX_W-1:HDR_W];
endmodule

// File: rtl/pkt_hdr_ecc_chk.sv
module pkt_hdr_ecc_chk
  import pkt_ecc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic             tx_in_valid,
  input logic             tx_in_ready,
  input logic [HDR_W-1:0] tx_in_hdr,
  input logic             tx_out_valid,
  input logic             tx_out_ready,
  input logic [PKT_W-1:0] tx_out_pkt,
  input logic             rx_in_valid,
  input logic             rx_in_ready,
  input logic [PKT_W-1:0] rx_in_pkt,
  input logic             rx_out_valid,
  input logic             rx_out_ready,
  input logic [HDR_W-1:0] rx_out_hdr,
  input logic [STS_W-1:0] rx_out_status
);
  assert_tx_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> tx_out_pkt[PKT_W-1:PKT_W-2] == 2'b00);

  assert_tx_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && !tx_en) |=>
      (tx_out_pkt == {{ECC_W{1'b0}}, $past(tx_in_hdr)}));

  assert_rx_no_code3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> rx_out_status != 2'b11);

  assert_rx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready && !rx_en) |=>
      (rx_out_status == 2'b00 && rx_out_hdr == $past(rx_in_pkt[HDR_W-1:0])));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_pkt)));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready) |=>
      (rx_out_valid && $stable(rx_out_hdr) && $stable(rx_out_status)));

  assert_tx_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_ready == (!tx_out_valid || tx_out_ready));

  assert_rx_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_ready == (!rx_out_valid || rx_out_ready));

  assert_tx_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready) |=> tx_out_valid);

  assert_rx_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready) |=> rx_out_valid);

  assert_reset_empty_R11: assert property (@(posedge clk)
    !rst_n |=> (!tx_out_valid && !rx_out_valid));
endmodule

bind pkt_hdr_ecc pkt_hdr_ecc_chk u_chk (.*);

// File: tb/pkt_hdr_ecc_bench.sv
module pkt_hdr_ecc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b1, rx_en = 1'b1;
  logic        tx_in_valid = 1'b0, tx_out_ready = 1'b1;
  logic [23:0] tx_in_hdr = '0;
  logic        rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic [31:0] rx_in_pkt = '0;
  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [31:0] tx_out_pkt;
  logic [23:0] rx_out_hdr;
  logic [1:0]  rx_out_status;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pkt_hdr_ecc u_pkt_hdr_ecc (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_hdr(tx_in_hdr),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_pkt(tx_out_pkt),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_pkt(rx_in_pkt),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_hdr(rx_out_hdr), .rx_out_status(rx_out_status)
  );

  function automatic logic [5:0] m_par(input logic [23:0] d);
    logic [5:0] p;
    p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    return p;
  endfunction

  function automatic logic [31:0] m_tx(input logic [23:0] h, input logic en);
    return en ? {2'b00, m_par(h), h} : {8'h00, h};
  endfunction

  // Returns {status, header}.
  function automatic logic [25:0] m_rx(input logic [31:0] pk, input logic en);
    logic [23:0] h;
    logic [5:0]  syn;
    h = pk[23:0];
    if (!en) return {2'b00, h};
    syn = pk[29:24] ^ m_par(h);
    if (syn == 6'd0) return {2'b00, h};
    if ($countones(syn) == 1) return {2'b01, h};
    for (int i = 0; i < 24; i++) begin
      if (m_par(h ^ (24'd1 << i)) == pk[29:24]) return {2'b01, h ^ (24'd1 << i)};
    end
    return {2'b10, h};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic tx_one(input logic [23:0] h, input logic en, input string tag);
    logic [31:0] e;
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_hdr = h; tx_en = en; tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    tx_en = ~en;  // later enable change must not matter (R12)
    e = m_tx(h, en);
    chk(tx_out_valid && tx_out_pkt == e, tag,
        $sformatf("tx hdr=%h en=%0d actual=%h/%0d expected=%h/1", h, en, tx_out_pkt, tx_out_valid, e));
  endtask

  task automatic rx_one(input logic [31:0] pk, input logic en, input string tag);
    logic [25:0] e;
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_pkt = pk; rx_en = en; rx_out_ready = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0;
    rx_en = ~en;
    e = m_rx(pk, en);
    chk(rx_out_valid && {rx_out_status, rx_out_hdr} == e, tag,
        $sformatf("rx pkt=%h en=%0d actual=%h/%0d expected=%h/1", pk, en,
                  {rx_out_status, rx_out_hdr}, rx_out_valid, e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] h;
    logic [31:0] pk;
    logic [31:0] a_exp;
    int k, b1, b2;
    void'($urandom(32'h5EED_0421));

    repeat (3) @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid, "R11",
        $sformatf("in reset valid actual=%0d%0d expected=00", tx_out_valid, rx_out_valid));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid && tx_in_ready && rx_in_ready, "R11",
        $sformatf("after reset actual=%0d%0d%0d%0d expected=0011",
                  tx_out_valid, rx_out_valid, tx_in_ready, rx_in_ready));

    // Directed transmit corners
    tx_one(24'h000000, 1'b1, "R1");
    tx_one(24'h800000, 1'b1, "R1");
    tx_one(24'hFFFFFF, 1'b1, "R2");
    tx_one(24'h0A0B3C, 1'b1, "R1");
    tx_one(24'hFFFFFF, 1'b0, "R3");
    tx_one(24'h123456, 1'b0, "R12");

    // Directed receive corners
    h = 24'h2C1A05;
    rx_one({2'b00, m_par(h), h}, 1'b1, "R4");
    rx_one({2'b11, m_par(h), h}, 1'b1, "R9");
    rx_one({2'b10, m_par(h), h ^ 24'h000001}, 1'b1, "R5");
    rx_one({2'b00, m_par(h), h ^ 24'h800000}, 1'b1, "R5");
    rx_one({2'b00, m_par(h) ^ 6'h20, h}, 1'b1, "R6");
    rx_one({2'b00, m_par(h), h ^ 24'h000003}, 1'b1, "R7");
    rx_one({2'b00, ~m_par(h), h}, 1'b1, "R7");
    rx_one({2'b00, m_par(h), h ^ 24'h000010}, 1'b0, "R8");
    rx_one({2'b01, ~m_par(h), h}, 1'b0, "R12");

    // Back-pressure on the transmit path
    @(negedge clk);
    tx_out_ready = 1'b0; tx_en = 1'b1;
    tx_in_valid = 1'b1; tx_in_hdr = 24'hABCDEF;
    @(negedge clk);
    a_exp = m_tx(24'hABCDEF, 1'b1);
    tx_in_hdr = 24'h111111;
    chk(!tx_in_ready, "R10", $sformatf("tx ready under stall actual=%0d expected=0", tx_in_ready));
    repeat (2) @(negedge clk);
    chk(tx_out_valid && tx_out_pkt == a_exp, "R10",
        $sformatf("tx hold actual=%h expected=%h", tx_out_pkt, a_exp));
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk(tx_out_valid && tx_out_pkt == m_tx(24'h111111, 1'b1), "R10",
        $sformatf("tx after stall actual=%h expected=%h", tx_out_pkt, m_tx(24'h111111, 1'b1)));

    // Back-pressure on the receive path
    @(negedge clk);
    rx_out_ready = 1'b0; rx_en = 1'b1;
    rx_in_valid = 1'b1; rx_in_pkt = {2'b00, m_par(h), h ^ 24'h000400};
    @(negedge clk);
    rx_in_valid = 1'b0;
    chk(!rx_in_ready, "R10", $sformatf("rx ready under stall actual=%0d expected=0", rx_in_ready));
    repeat (2) @(negedge clk);
    chk(rx_out_valid && rx_out_hdr == h && rx_out_status == 2'b01, "R10",
        $sformatf("rx hold actual=%h/%0d expected=%h/1", rx_out_hdr, rx_out_status, h));
    rx_out_ready = 1'b1;
    @(negedge clk);
    chk(!rx_out_valid, "R10", $sformatf("rx drain actual=%0d expected=0", rx_out_valid));

    // Random transmit
    for (int n = 0; n < 300; n++) begin
      tx_one($urandom() & 24'hFFFFFF, ($urandom() % 10) != 0, "R1");
    end

    // Random receive with corruption classes
    for (int n = 0; n < 400; n++) begin
      h  = $urandom() & 24'hFFFFFF;
      pk = {2'($urandom()), m_par(h), h};
      k  = $urandom() % 5;
      b1 = $urandom() % 24;
      b2 = (b1 + 1 + ($urandom() % 23)) % 24;
      case (k)
        1: pk[b1] = ~pk[b1];
        2: pk[24 + ($urandom() % 6)] ^= 1'b1;
        3: begin pk[b1] = ~pk[b1]; pk[b2] = ~pk[b2]; end
        4: pk = $urandom();
        default: ;
      endcase
      rx_one(pk, ($urandom() % 10) != 0, k == 1 ? "R5" : k == 2 ? "R6" : k == 0 ? "R4" : "R7");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule